// File: doc/BRIEF.md
# Clock Source Switching Controller

This controller decides which of eight oscillator sources drives the system clock. Each source has a 3-bit code, and `clk_sel` has one line per code. The code given on `cfg_init_src` is captured while reset is asserted. If two-speed start-up is off, the block leaves reset already on that source. If it is on, the block leaves reset on the plain fast RC source (code 000) with a switch pending, and it moves to the chosen source on the first cycle that source is usable.

After start-up, software can ask for another source with `sw_req` and `sw_target`. A switch is made only when the target's ready flag is high and its qualifiers are met. The first qualifier is the PLL lock, which applies to the PLL-based codes when `cfg_lock_wait` is set. The second is the primary oscillator mode field, which can disable the primary-based codes. The switching-mode field can refuse runtime requests, and it can also turn on a monitor. The monitor falls back to the fast RC source when the active source's ready flag stays low for too long.

The source code table is:

| Code | Source |
|------|--------|
| 000 | fast RC |
| 001 | fast RC with PLL |
| 010 | primary |
| 011 | primary with PLL |
| 100 | secondary low-power oscillator |
| 101 | low-power RC |
| 110 | fast RC divided by 16 |
| 111 | fast RC with postscaler |

Top module: `clksw_ctrl`

## Requirements
- R1: While `rst` is high with `cfg_two_speed`=0, the block loads `active_src`=`cfg_init_src`, `switch_pending`=0, `req_rejected`=0 and `clk_fail`=0.
- R2: While `rst` is high with `cfg_two_speed`=1, the block loads `active_src`=000 and `switch_pending`=1, with the target set to `cfg_init_src`. The block moves to that target on the first clock edge at which the target is usable.
- R3: `cfg_init_src` is sampled only while `rst` is high. Changing it afterwards does not alter `active_src` or `switch_pending`.
- R4: `clk_sel` is always one-hot, and bit k is set exactly when `active_src`=k. `active_src` takes a new value only in two cases: the target was usable in the previous cycle, or the fail-safe action occurred.
- R5: When `cfg_sw_mode[1]`=0 and no fail-safe action occurs, a `sw_req` pulse loads `sw_target` and sets `switch_pending` on the next cycle. The switch completes on the first later edge at which the target is usable.
- R6: When `cfg_sw_mode[1]`=1, `sw_req` leaves `active_src` and `switch_pending` unchanged and sets the sticky flag `req_rejected`.
- R7: When `cfg_lock_wait`=1, codes 001 and 011 count as usable only while `pll_locked`=1. When `cfg_lock_wait`=0, the PLL lock is not considered.
- R8: When `cfg_pri_mode`=11, codes 010 and 011 are never usable. The other values of `cfg_pri_mode` (10 HS crystal, 01 XT crystal, 00 external clock) leave them governed by their ready flags.
- R9: With `cfg_sw_mode`=00, the fail-safe action occurs when the active source's ready flag is low on more than 8 consecutive edges. On the next cycle this gives `active_src`=000, `switch_pending`=0 and sticky `clk_fail`=1. Eight low edges are tolerated.
- R10: With `cfg_sw_mode` other than 00, a missing ready flag never sets `clk_fail` or changes the source.
- R11: A request accepted while a switch is still pending replaces the old target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_init_src | input | SRC_W | Initial source code, sampled at reset |
| cfg_two_speed | input | 1 | Start on fast RC, then move to the initial source |
| cfg_sw_mode | input | 2 | 1x: no switching, no monitor; 01: switching only; 00: both |
| cfg_lock_wait | input | 1 | PLL-based sources wait for PLL lock |
| cfg_pri_mode | input | 2 | Primary oscillator mode; 11 disables the primary |
| src_ready | input | 2**SRC_W | Ready flag per source code |
| pll_locked | input | 1 | PLL lock indication |
| sw_req | input | 1 | One-cycle runtime switch request |
| sw_target | input | SRC_W | Requested source code |
| clk_sel | output | 2**SRC_W | One-hot source select |
| active_src | output | SRC_W | Code of the selected source |
| switch_pending | output | 1 | A switch waits for its target |
| req_rejected | output | 1 | Sticky: a request arrived while switching was disabled |
| clk_fail | output | 1 | Sticky: fail-safe fallback taken |

## Verification
The assertions assume that `rst` is high on the first clock edge and that every input is a defined level once reset has been applied. They also assume that `sw_req` and all configuration fields are synchronous to `clk`. The stimulus changes every input only on the falling edge, so each value is steady at the sampling edge. It also pulses `sw_req` for exactly one cycle and keeps the fast RC ready flag high. Together these hold the fallback target usable, so the "change only when usable" property is exercised on real switches and not on a dead fast RC source.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

  localparam int CODE_FRC     = 0;
  localparam int CODE_FRC_PLL = 1;
  localparam int CODE_PRI     = 2;
  localparam int CODE_PRI_PLL = 3;
  localparam logic [1:0] PRI_OFF = 2'b11;

  // sources fed through the PLL
  function automatic logic via_pll(input int code);
    return (code == CODE_FRC_PLL) || (code == CODE_PRI_PLL);
  endfunction

  // sources built on the primary oscillator
  function automatic logic via_primary(input int code);
    return (code == CODE_PRI) || (code == CODE_PRI_PLL);
  endfunction

endpackage

// File: rtl/clksw_src_qual.sv
module clksw_src_qual
  import clksw_pkg::*;
#(
  parameter int CODE = 0
) (
  input  logic       raw_ready,
  input  logic       pll_locked,
  input  logic       lock_wait,
  input  logic [1:0] pri_mode,
  output logic       usable
);

  always_comb begin
    usable = raw_ready;
    if (via_primary(CODE) && pri_mode == PRI_OFF) usable = 1'b0;
    if (via_pll(CODE) && lock_wait && !pll_locked) usable = 1'b0;
  end

endmodule

// File: rtl/clksw_fail_mon.sv
module clksw_fail_mon #(
  parameter int LIM = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic active_ready,
  output logic trip
);

  localparam int CNT_W = $clog2(LIM + 1);

  logic [CNT_W-1:0] low_cnt;

  assign trip = enable && !active_ready && (low_cnt == CNT_W'(LIM));

  always_ff @(posedge clk) begin
    if (rst || !enable || active_ready || trip) low_cnt <= '0;
    else                                         low_cnt <= low_cnt + 1'b1;
  end

  // R10: a disabled monitor must never count
  assert_idle_when_off_R10: assert property (@(posedge clk) disable iff (rst)
    !enable |=> low_cnt == '0);

endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter int SRC_W    = 3,
  parameter int FAIL_LIM = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [SRC_W-1:0]       cfg_init_src,
  input  logic                   cfg_two_speed,
  input  logic [1:0]             cfg_sw_mode,
  input  logic                   cfg_lock_wait,
  input  logic [1:0]             cfg_pri_mode,
  input  logic [(1<<SRC_W)-1:0]  src_ready,
  input  logic                   pll_locked,
  input  logic                   sw_req,
  input  logic [SRC_W-1:0]       sw_target,
  output logic [(1<<SRC_W)-1:0]  clk_sel,
  output logic [SRC_W-1:0]       active_src,
  output logic                   switch_pending,
  output logic                   req_rejected,
  output logic                   clk_fail
);

  localparam int NSRC = 1 << SRC_W;
  localparam logic [NSRC-1:0] SEL_ONE = {{(NSRC-1){1'b0}}, 1'b1};

  logic [NSRC-1:0]  ok_vec;
  logic [SRC_W-1:0] cur_q, tgt_q, nxt_cur, nxt_tgt;
  logic             pend_q, rej_q, fail_q, run_q;
  logic             nxt_pend, nxt_rej, nxt_fail;
  logic             trip, mon_en, req_ok;

  for (genvar i = 0; i < NSRC; i++) begin : g_qual
    clksw_src_qual #(.CODE(i)) u_qual (
      .raw_ready (src_ready[i]),
      .pll_locked(pll_locked),
      .lock_wait (cfg_lock_wait),
      .pri_mode  (cfg_pri_mode),
      .usable    (ok_vec[i])
    );
  end

  assign mon_en = (cfg_sw_mode == 2'b00);

  clksw_fail_mon #(.LIM(FAIL_LIM)) u_mon (
    .clk         (clk),
    .rst         (rst),
    .enable      (mon_en),
    .active_ready(src_ready[cur_q]),
    .trip        (trip)
  );

  assign req_ok = sw_req && !cfg_sw_mode[1];

  always_comb begin
    nxt_cur  = cur_q;
    nxt_tgt  = tgt_q;
    nxt_pend = pend_q;
    nxt_rej  = rej_q || (sw_req && cfg_sw_mode[1]);
    nxt_fail = fail_q;
    if (trip) begin
      nxt_cur  = '0;
      nxt_pend = 1'b0;
      nxt_fail = 1'b1;
    end else if (req_ok) begin
      nxt_tgt  = sw_target;
      nxt_pend = 1'b1;
    end else if (pend_q && ok_vec[tgt_q]) begin
      nxt_cur  = tgt_q;
      nxt_pend = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q   <= cfg_two_speed ? '0 : cfg_init_src;
      clk_sel <= cfg_two_speed ? SEL_ONE : (SEL_ONE << cfg_init_src);
      tgt_q   <= cfg_init_src;
      pend_q  <= cfg_two_speed;
      rej_q   <= 1'b0;
      fail_q  <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      cur_q   <= nxt_cur;
      clk_sel <= SEL_ONE << nxt_cur;
      tgt_q   <= nxt_tgt;
      pend_q  <= nxt_pend;
      rej_q   <= nxt_rej;
      fail_q  <= nxt_fail;
      run_q   <= 1'b1;
    end
  end

  assign active_src     = cur_q;
  assign switch_pending = pend_q;
  assign req_rejected   = rej_q;
  assign clk_fail       = fail_q;

  assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot(clk_sel) && clk_sel[cur_q]);

  assert_switch_when_usable_R4: assert property (@(posedge clk) disable iff (rst)
    (run_q && cur_q != $past(cur_q) && !$past(trip)) |->
      (cur_q == $past(tgt_q)) && $past(ok_vec[tgt_q]));

  assert_request_taken_R5: assert property (@(posedge clk) disable iff (rst)
    (req_ok && !trip) |=> switch_pending);

  assert_request_refused_R6: assert property (@(posedge clk) disable iff (rst)
    (sw_req && cfg_sw_mode[1]) |=> req_rejected);

  assert_lock_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (pend_q && via_pll(int'(tgt_q)) && cfg_lock_wait && !pll_locked && !trip)
      |=> cur_q == $past(cur_q));

  assert_fallback_R9: assert property (@(posedge clk) disable iff (rst)
    trip |=> clk_fail && active_src == '0 && !switch_pending);

  assert_no_fail_off_R10: assert property (@(posedge clk) disable iff (rst)
    (!fail_q && !mon_en) |=> !clk_fail);

endmodule

// File: tb/sim_clksw_ctrl.sv
module sim_clksw_ctrl;

  localparam int SRC_W = 3;
  localparam int NSRC  = 8;
  localparam int LIM   = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [SRC_W-1:0] cfg_init_src = '0;
  logic             cfg_two_speed = 1'b0;
  logic [1:0]       cfg_sw_mode = 2'b01;
  logic             cfg_lock_wait = 1'b0;
  logic [1:0]       cfg_pri_mode = 2'b01;
  logic [NSRC-1:0]  src_ready = '1;
  logic             pll_locked = 1'b0;
  logic             sw_req = 1'b0;
  logic [SRC_W-1:0] sw_target = '0;
  logic [NSRC-1:0]  clk_sel;
  logic [SRC_W-1:0] active_src;
  logic             switch_pending, req_rejected, clk_fail;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  int m_cur, m_tgt, m_cnt;
  bit m_pend, m_rej, m_fail, m_valid = 0;

  always #10 clk = ~clk;

  clksw_ctrl #(.SRC_W(SRC_W), .FAIL_LIM(LIM)) u0 (
    .clk(clk), .rst(rst), .cfg_init_src(cfg_init_src),
    .cfg_two_speed(cfg_two_speed), .cfg_sw_mode(cfg_sw_mode),
    .cfg_lock_wait(cfg_lock_wait), .cfg_pri_mode(cfg_pri_mode),
    .src_ready(src_ready), .pll_locked(pll_locked), .sw_req(sw_req),
    .sw_target(sw_target), .clk_sel(clk_sel), .active_src(active_src),
    .switch_pending(switch_pending), .req_rejected(req_rejected),
    .clk_fail(clk_fail)
  );

  function automatic bit usable(int code);
    if (!src_ready[code]) return 0;
    if ((code == 2 || code == 3) && cfg_pri_mode == 2'b11) return 0;
    if ((code == 1 || code == 3) && cfg_lock_wait && !pll_locked) return 0;
    return 1;
  endfunction

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_cur = cfg_two_speed ? 0 : int'(cfg_init_src);
      m_tgt = int'(cfg_init_src);
      m_pend = cfg_two_speed;
      m_rej = 0; m_fail = 0; m_cnt = 0; m_valid = 1;
    end else begin
      bit hit, was_low;
      was_low = !src_ready[m_cur];
      hit = (cfg_sw_mode == 2'b00) && was_low && (m_cnt == LIM);
      if (cfg_sw_mode != 2'b00 || !was_low || hit) m_cnt = 0;
      else m_cnt = m_cnt + 1;
      if (sw_req && cfg_sw_mode[1]) m_rej = 1;
      if (hit) begin
        m_cur = 0; m_pend = 0; m_fail = 1;
      end else if (sw_req && !cfg_sw_mode[1]) begin
        m_tgt = int'(sw_target); m_pend = 1;
      end else if (m_pend && usable(m_tgt)) begin
        m_cur = m_tgt; m_pend = 0;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (m_valid) begin
      check("R4 clk_sel", int'(clk_sel), 1 << m_cur);
      check("R4 active_src", int'(active_src), m_cur);
      check("R5 switch_pending", int'(switch_pending), int'(m_pend));
      check("R6 req_rejected", int'(req_rejected), int'(m_rej));
      check("R9 clk_fail", int'(clk_fail), int'(m_fail));
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(int init, bit two);
    rst = 1; cfg_init_src = SRC_W'(init); cfg_two_speed = two;
    step(2);
    rst = 0;
  endtask

  task automatic request(int t);
    sw_target = SRC_W'(t); sw_req = 1;
    step(1);
    sw_req = 0;
  endtask

  initial begin : watchdog
    step(100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: direct start
    do_reset(2, 0);
    check("R1 src", int'(active_src), 2);
    check("R1 pending", int'(switch_pending), 0);
    check("R1 flags", int'({req_rejected, clk_fail}), 0);
    // R3: initial code ignored after reset
    cfg_init_src = 3'd5;
    step(3);
    check("R3 src", int'(active_src), 2);
    check("R3 pending", int'(switch_pending), 0);
    // R5/R4: wait for ready, then switch
    src_ready[5] = 0;
    request(5);
    check("R5 pending", int'(switch_pending), 1);
    step(3);
    check("R4 held", int'(active_src), 2);
    src_ready[5] = 1;
    step(1);
    check("R5 switched", int'(active_src), 5);
    check("R4 sel", int'(clk_sel), 32);
    // R7: lock wait
    cfg_lock_wait = 1; pll_locked = 0;
    request(3);
    step(4);
    check("R7 held", int'(active_src), 5);
    pll_locked = 1;
    step(1);
    check("R7 locked", int'(active_src), 3);
    cfg_lock_wait = 0; pll_locked = 0;
    request(1);
    step(1);
    check("R7 no wait", int'(active_src), 1);
    // R8: primary disabled
    cfg_pri_mode = 2'b11;
    request(2);
    step(3);
    check("R8 held", int'(active_src), 1);
    cfg_pri_mode = 2'b10;
    step(1);
    check("R8 enabled", int'(active_src), 2);
    // R6: switching disabled
    cfg_sw_mode = 2'b10;
    request(0);
    check("R6 rejected", int'(req_rejected), 1);
    check("R6 pending", int'(switch_pending), 0);
    step(2);
    check("R6 src", int'(active_src), 2);
    // R9: monitor tolerance and trip
    cfg_sw_mode = 2'b00;
    src_ready[2] = 0;
    step(8);
    src_ready[2] = 1;
    step(2);
    check("R9 tolerated", int'(clk_fail), 0);
    src_ready[2] = 0;
    step(8);
    check("R9 not yet", int'(clk_fail), 0);
    step(1);
    check("R9 fail", int'(clk_fail), 1);
    check("R9 fallback", int'(active_src), 0);
    src_ready[2] = 1;
    // R10: monitor off
    cfg_sw_mode = 2'b01;
    do_reset(2, 0);
    src_ready[2] = 0;
    step(20);
    check("R10 no fail", int'(clk_fail), 0);
    check("R10 src", int'(active_src), 2);
    src_ready[2] = 1;
    // R11: replacement of target
    src_ready[4] = 0;
    request(4);
    step(2);
    request(6);
    step(1);
    check("R11 src", int'(active_src), 6);
    check("R11 pending", int'(switch_pending), 0);
    src_ready[4] = 1;
    // R2: two-speed start-up
    cfg_lock_wait = 1; pll_locked = 0;
    do_reset(3, 1);
    check("R2 start", int'(active_src), 0);
    check("R2 pending", int'(switch_pending), 1);
    step(3);
    check("R2 waiting", int'(active_src), 0);
    pll_locked = 1;
    step(1);
    check("R2 moved", int'(active_src), 3);
    check("R2 done", int'(switch_pending), 0);
    step(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule